// File: doc/BRIEF.md
# Six-Pin GPIO Port with Shared Serial Slave-Select

This block is a six-pin general-purpose I/O port in which one pin (index 5) also serves as the active-low slave-select input of a serial peripheral engine. It holds three registers, all written over a simple CPU register interface:

- a per-pin output data register;
- a per-pin direction register;
- a single port-wide open-drain enable.

From these registers and the serial engine's role, the block forms each pad's output-enable and drive value. It also supplies a read-back value whose source depends on whether the pin's driver is enabled.

Pad inputs pass through a two-flop synchronizer before any use. The synchronized slave-select pin is inverted into an active-high select for the serial core. That select is suppressed whenever the serial engine is off, or when the pin is being used as a plain output in master mode.

The serial engine's role can take the direction of the slave-select pin out of software control. When the engine is a slave, the pin is always an input. When the engine is a master, the pin follows its direction bit like any other pin.

Top module: `gpio_spi_port`

## Requirements
- R1: After reset, the data register, the direction register and the open-drain bit are all zero, so every `pad_oe` bit is low and every register reads back as zero.
- R2: A cycle with `reg_wr` high latches `reg_wdata` on the following clock edge. The target is selected by `reg_addr`: 0 selects the data register, 1 the direction register, and 2 the control register, where bit 0 is the open-drain enable. Address 1 reads back the direction register, and address 2 reads the open-drain bit in bit 0 with zeros above it.
- R3: With the serial engine disabled and the open-drain bit clear, `pad_oe[i]` equals direction bit i and `pad_out[i]` equals data bit i for every pin.
- R4: With `spi_en`=1 and `spi_master`=0, the driver of pin 5 is off (`pad_oe[5]`=0) whatever its direction bit holds.
- R5: With `spi_en`=1 and `spi_master`=1, pin 5's driver enable follows its direction bit alone.
- R6: With the open-drain bit set, a pin whose driver is enabled and whose data bit is 1 has `pad_oe` low (pad released to an external pull-up), while a pin with data 0 keeps `pad_oe` high and drives 0. The bit acts on all six pins at once.
- R7: A read at address 0 returns, for each pin whose driver is enabled, the data register bit; for every other pin it returns the synchronized pad level, which lags `pad_in` by two clock edges.
- R8: With the serial engine enabled and pin 5's driver disabled, `ss_act` is the inverse of the synchronized `pad_in[5]`.
- R9: `ss_act` is 0 whenever `spi_en` is 0.
- R10: `ss_act` is 0 when `spi_en`=1, `spi_master`=1 and direction bit 5 is 1, whatever the pad level.
- R11: A write at address 3 changes no register and no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 data, 1 direction, 2 control, 3 unused |
| reg_wdata | input | 6 | Write data |
| reg_rdata | output | 6 | Read data for the selected register |
| spi_en | input | 1 | Serial engine enabled |
| spi_master | input | 1 | Serial engine in master role |
| pad_in | input | 6 | Pad input levels (asynchronous) |
| pad_oe | output | 6 | Pad output enable per pin |
| pad_out | output | 6 | Pad drive value per pin |
| ss_act | output | 1 | Qualified active-high slave select to the serial core |

## Verification
The bench builds the port at its default width of six pins, with the shared pin at index 5. That small size makes every pairing of data and direction contents (4096 of them) reachable under each of the four serial-role settings and both open-drain settings. Two pad patterns per role place the slave-select pad at both levels. As a result, the direction override, the open-drain release, the read-source choice and every slave-select gating case are each observed on every pin against arithmetically computed values.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    ADDR_DATA = 2'd0,
    ADDR_DIR  = 2'd1,
    ADDR_CTRL = 2'd2,
    ADDR_RSVD = 2'd3
  } port_addr_e;

  localparam int unsigned CTRL_WOR_BIT = 0;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int unsigned WIDTH  = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_comb stage_d[s] = async_in;
      end else begin : g_next
        always_comb stage_d[s] = stage_q[s-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[s] <= '0;
        end else begin
          stage_q[s] <= stage_d[s];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] data_q,
  output logic [WIDTH-1:0] dir_q,
  output logic             wor_q
);
  port_addr_e       sel;
  logic             data_we;
  logic             dir_we;
  logic             ctrl_we;
  logic [WIDTH-1:0] data_d;
  logic [WIDTH-1:0] dir_d;
  logic             wor_d;

  always_comb begin
    sel     = port_addr_e'(wr_addr);
    data_we = wr_en && (sel == ADDR_DATA);
    dir_we  = wr_en && (sel == ADDR_DIR);
    ctrl_we = wr_en && (sel == ADDR_CTRL);
    data_d  = data_we ? wr_data : data_q;
    dir_d   = dir_we  ? wr_data : dir_q;
    wor_d   = ctrl_we ? wr_data[CTRL_WOR_BIT] : wor_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
      wor_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      dir_q  <= dir_d;
      wor_q  <= wor_d;
    end
  end
endmodule

// File: rtl/gpio_drive_ctl.sv
module gpio_drive_ctl #(
  parameter int unsigned WIDTH  = 6,
  parameter int unsigned SS_IDX = 5
) (
  input  logic             spi_en,
  input  logic             spi_master,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] data_q,
  input  logic             wor_q,
  input  logic [WIDTH-1:0] pad_sync,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] rd_pins,
  output logic             ss_act
);
  logic [WIDTH-1:0] drv_en;
  logic             slave_role;

  assign slave_role = spi_en && !spi_master;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      if (i == SS_IDX) begin : g_shared
        // Slave role takes the pin away from software; otherwise the direction bit rules.
        always_comb drv_en[i] = dir_q[i] && !slave_role;
      end else begin : g_plain
        always_comb drv_en[i] = dir_q[i];
      end

      always_comb begin
        // Open-drain: a driven one releases the pad, a driven zero still sinks.
        pad_oe[i]  = drv_en[i] && !(wor_q && data_q[i]);
        pad_out[i] = data_q[i];
        rd_pins[i] = drv_en[i] ? data_q[i] : pad_sync[i];
      end
    end
  endgenerate

  // Select is only qualified while the engine is on and the pin is not driving.
  assign ss_act = spi_en && !drv_en[SS_IDX] && !pad_sync[SS_IDX];
endmodule

// File: rtl/gpio_spi_port.sv
module gpio_spi_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH       = 6,
  parameter int unsigned SS_IDX      = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [WIDTH-1:0] reg_wdata,
  output logic [WIDTH-1:0] reg_rdata,
  input  logic             spi_en,
  input  logic             spi_master,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_out,
  output logic             ss_act
);
  localparam int unsigned CTRL_PAD = WIDTH - 1;

  logic             rst_ni;
  logic [WIDTH-1:0] data_q;
  logic [WIDTH-1:0] dir_q;
  logic             wor_q;
  logic [WIDTH-1:0] pad_sync;
  logic [WIDTH-1:0] rd_pins;
  port_addr_e       rd_sel;

  gpio_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_ni)
  );

  gpio_port_regs #(.WIDTH(WIDTH)) regs_i (
    .clk     (clk),
    .rst_n   (rst_ni),
    .wr_en   (reg_wr),
    .wr_addr (reg_addr),
    .wr_data (reg_wdata),
    .data_q  (data_q),
    .dir_q   (dir_q),
    .wor_q   (wor_q)
  );

  gpio_pad_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) pad_sync_i (
    .clk      (clk),
    .rst_n    (rst_ni),
    .async_in (pad_in),
    .sync_out (pad_sync)
  );

  gpio_drive_ctl #(.WIDTH(WIDTH), .SS_IDX(SS_IDX)) drive_i (
    .spi_en     (spi_en),
    .spi_master (spi_master),
    .dir_q      (dir_q),
    .data_q     (data_q),
    .wor_q      (wor_q),
    .pad_sync   (pad_sync),
    .pad_oe     (pad_oe),
    .pad_out    (pad_out),
    .rd_pins    (rd_pins),
    .ss_act     (ss_act)
  );

  always_comb begin
    rd_sel = port_addr_e'(reg_addr);
    unique case (rd_sel)
      ADDR_DATA: reg_rdata = rd_pins;
      ADDR_DIR:  reg_rdata = dir_q;
      ADDR_CTRL: reg_rdata = {{CTRL_PAD{1'b0}}, wor_q};
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_spi_port_chk.sv
module gpio_spi_port_chk #(
  parameter int unsigned WIDTH  = 6,
  parameter int unsigned SS_IDX = 5
) (
  input logic             clk,
  input logic             rst_ni,
  input logic             reg_wr,
  input logic [1:0]       reg_addr,
  input logic [WIDTH-1:0] reg_wdata,
  input logic             spi_en,
  input logic             spi_master,
  input logic [WIDTH-1:0] dir_q,
  input logic             wor_q,
  input logic [WIDTH-1:0] pad_oe,
  input logic [WIDTH-1:0] pad_out,
  input logic             ss_act
);
  assert_dir_latch_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (reg_wr && reg_addr == 2'd1) |=> (dir_q == $past(reg_wdata)));

  assert_plain_dir_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (!spi_en && !wor_q) |-> (pad_oe == dir_q));

  assert_slave_off_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (spi_en && !spi_master) |-> !pad_oe[SS_IDX]);

  assert_master_dir_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (spi_en && spi_master && !wor_q) |-> (pad_oe[SS_IDX] == dir_q[SS_IDX]));

  assert_wor_release_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    wor_q |-> ((pad_oe & pad_out) == '0));

  assert_ss_off_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    !spi_en |-> !ss_act);

  assert_ss_master_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    (spi_en && spi_master && dir_q[SS_IDX]) |-> !ss_act);

  assert_no_write_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    (reg_wr && reg_addr == 2'd3) |=> ($stable(dir_q) && $stable(wor_q)));
endmodule

bind gpio_spi_port gpio_spi_port_chk #(.WIDTH(WIDTH), .SS_IDX(SS_IDX)) chk_i (
  .clk        (clk),
  .rst_ni     (rst_ni),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .spi_en     (spi_en),
  .spi_master (spi_master),
  .dir_q      (dir_q),
  .wor_q      (wor_q),
  .pad_oe     (pad_oe),
  .pad_out    (pad_out),
  .ss_act     (ss_act)
);

// File: tb/gpio_spi_port_tb_top.sv
module gpio_spi_port_tb_top;
  localparam int W  = 6;
  localparam int SS = 5;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr = 1'b0;
  logic [1:0]   reg_addr = 2'd0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic         spi_en = 1'b0;
  logic         spi_master = 1'b0;
  logic [W-1:0] pad_in = '0;
  logic [W-1:0] pad_oe;
  logic [W-1:0] pad_out;
  logic         ss_act;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  gpio_spi_port #(.WIDTH(W), .SS_IDX(SS)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .spi_en     (spi_en),
    .spi_master (spi_master),
    .pad_in     (pad_in),
    .pad_oe     (pad_oe),
    .pad_out    (pad_out),
    .ss_act     (ss_act)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    reg_wr    = 1'b1;
    reg_addr  = a;
    reg_wdata = d;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic read_at(input logic [1:0] a, output logic [W-1:0] v);
    reg_addr = a;
    #0.5;
    v = reg_rdata;
  endtask

  initial begin
    logic [W-1:0] rv;
    logic [W-1:0] pad;
    logic [W-1:0] drv;
    logic [W-1:0] exp_oe;
    logic [W-1:0] exp_rd;
    logic         exp_ss;
    logic         en;
    logic         ms;
    string        oe_tag;
    string        ss_tag;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 pad_oe", 8'(pad_oe), 8'h00);
    read_at(2'd0, rv); check("R1 data", 8'(rv), 8'h00);
    read_at(2'd1, rv); check("R1 dir", 8'(rv), 8'h00);
    read_at(2'd2, rv); check("R1 ctrl", 8'(rv), 8'h00);
    check("R9 ss after reset", 8'(ss_act), 8'h00);

    // R2 control register readback
    reg_write(2'd2, 6'h3F);
    read_at(2'd2, rv); check("R2 ctrl", 8'(rv), 8'h01);
    reg_write(2'd2, 6'h00);
    read_at(2'd2, rv); check("R2 ctrl clear", 8'(rv), 8'h00);

    // R11 unused address
    reg_write(2'd0, 6'h15);
    reg_write(2'd1, 6'h0C);
    reg_write(2'd3, 6'h3F);
    @(negedge clk);
    read_at(2'd1, rv); check("R11 dir", 8'(rv), 8'h0C);
    read_at(2'd2, rv); check("R11 ctrl", 8'(rv), 8'h00);
    check("R11 pad_out", 8'(pad_out), 8'h15);
    check("R11 pad_oe", 8'(pad_oe), 8'h0C);

    // R7 synchronizer latency: pins as inputs
    reg_write(2'd1, 6'h00);
    @(negedge clk);
    pad_in = 6'h2A;
    @(negedge clk);
    read_at(2'd0, rv); check("R7 one edge", 8'(rv), 8'h00);
    @(negedge clk);
    read_at(2'd0, rv); check("R7 two edges", 8'(rv), 8'h2A);

    // Sweep: role x open-drain x data x direction
    for (int mode = 0; mode < 4; mode++) begin
      en = mode[1];
      ms = mode[0];
      for (int w = 0; w < 2; w++) begin
        reg_write(2'd2, W'(w));
        @(negedge clk);
        spi_en     = en;
        spi_master = ms;
        pad        = 6'b011010 ^ {W{w[0]}} ^ W'(mode * 5);
        pad_in     = pad;
        repeat (3) @(negedge clk);
        for (int dv = 0; dv < 64; dv++) begin
          for (int dr = 0; dr < 64; dr++) begin
            reg_write(2'd0, W'(dv));
            reg_write(2'd1, W'(dr));
            drv = W'(dr);
            if (en && !ms) drv[SS] = 1'b0;
            exp_oe = drv & ~(w[0] ? W'(dv) : '0);
            exp_rd = (drv & W'(dv)) | (~drv & pad);
            exp_ss = en && !drv[SS] && !pad[SS];
            if (w[0])             oe_tag = "R6 pad_oe";
            else if (en && !ms)   oe_tag = "R4 pad_oe";
            else if (en)          oe_tag = "R5 pad_oe";
            else                  oe_tag = "R3 pad_oe";
            if (!en)              ss_tag = "R9 ss_act";
            else if (ms && dr[SS]) ss_tag = "R10 ss_act";
            else                  ss_tag = "R8 ss_act";
            check(oe_tag, 8'(pad_oe), 8'(exp_oe));
            check("R3 pad_out", 8'(pad_out), 8'(dv));
            check(ss_tag, 8'(ss_act), 8'(exp_ss));
            read_at(2'd0, rv); check("R7 readback", 8'(rv), 8'(exp_rd));
            read_at(2'd1, rv); check("R2 dir", 8'(rv), 8'(dr));
          end
        end
      end
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end
endmodule